// File: doc/BRIEF.md
# Data Window Address Translator

This block turns a logical data address into a physical address in a wider space made of several target regions. The logical range is cut into four equal windows of 16 KB. Each window has a 16-bit mapping register. The register picks the region the window lands in and a segment within that region. It can also switch the window into an I/O mode, where each 4 KB quarter of the window is steered to its own I/O bank.

Each access presents a logical offset and a requested byte count. The block returns the physical address, the number of bytes that may be moved without leaving the window, a tag naming the target region, and a fault flag. The translation path is combinational. The mapping registers are written through a simple one-cycle write port, and the register addressed by that port is always visible on a read-back output.

Top module: `dwt_translator`

## Requirements
- R1: After reset the mapping registers for windows 0, 1, 2 and 3 hold 0x2000, 0x2000, 0x2000 and 0x0000. Each value is seen on `map_rd` when `map_sel` selects that window.
- R2: A write (`map_we` high) updates the selected register at the next rising clock edge. A translation presented in the same cycle as the write uses the value the register held before that write.
- R3: The window index is `log_addr[15:14]` and the in-window offset is `log_addr[13:0]`. An address of 0x10000 or more sets `fault`, gives tag 7 and returns zero for both `phys_addr` and `grant_len`.
- R4: When there is no fault, `grant_len` is the smaller of `req_len` and (0x4000 minus the in-window offset). An access therefore never crosses a window boundary.
- R5: When register bit 15 is 0 and bits 13:12 are 00, the access goes to unified memory with tag 0. The address is phys = 0x0000_0000 + segment × 0x4000 + offset, where the segment is register bits 9:0.
- R6: When register bit 15 is 0 and bits 13:12 are 01, the access goes to instruction memory with tag 1. The address is phys = 0x0100_0000 + segment × 0x4000 + offset.
- R7: When register bit 15 is 0 and bits 13:12 are 10, the access goes to internal data memory with tag 2. The address is phys = 0x0200_0000 + (segment << 16) + window index × 0x4000 + offset.
- R8: When register bit 15 is 0 and bits 13:12 are 11, the access faults with tag 7 and returns zero for both `phys_addr` and `grant_len`.
- R9: When register bit 15 is 1, the window is in I/O mode with tag 3 and bits 13:12 are ignored. The sub-bank is k = offset[13:12]. It selects register nibble (3 − k), where nibble n is bits 4n+3:4n. The address is phys = 0x0200_0000 + nibble × 0x10000 + 0xC000 + offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_addr | input | 17 | Logical offset to translate |
| req_len | input | 16 | Requested byte count |
| map_we | input | 1 | Mapping register write strobe |
| map_sel | input | 2 | Register index for write and read-back |
| map_wdata | input | 16 | Write data |
| map_rd | output | 16 | Current value of the selected register |
| phys_addr | output | 32 | Translated physical address |
| grant_len | output | 16 | Allowed byte count |
| space_tag | output | 3 | Target region tag (0 unified, 1 instruction, 2 data, 3 I/O, 7 none) |
| fault | output | 1 | Range or reserved-region fault |

## Verification
A wrong mapping register shows up in the very next combinational translation through that window. It appears at once on `map_rd` when that window is selected, so every register is read back both right after reset and right after each write. A write that lands one cycle too early is exposed by translating through the written window in the cycle of the write itself. A fault in segment shifting, nibble selection or clipping shows as a wrong address or length in the same cycle as the access. The stimulus places offsets at window and sub-bank edges so that bit-slice errors cannot hide.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int MAP_W = 16;

    typedef logic [MAP_W-1:0] map_word_t;

    typedef enum logic [2:0] {
        SP_UNIFIED = 3'd0,
        SP_INSN    = 3'd1,
        SP_DATA    = 3'd2,
        SP_IO      = 3'd3,
        SP_NONE    = 3'd7
    } space_e;

    typedef struct packed {
        logic       io_mode;
        logic [1:0] region;
        logic [9:0] segment;
    } map_fields_t;

    typedef struct packed {
        logic [31:0] addr;
        space_e      space;
        logic        bad;
    } map_result_t;

    localparam logic [31:0] UNI_BASE   = 32'h0000_0000;
    localparam logic [31:0] INSN_BASE  = 32'h0100_0000;
    localparam logic [31:0] DATA_BASE  = 32'h0200_0000;
    localparam logic [31:0] IO_LOW     = 32'h0000_C000;
    localparam int          IO_STRIDE_SH = 16;
    localparam int          IO_BANK_SH   = 12;
    localparam int          DSEG_SH      = 16;

    function automatic map_fields_t split_map(input map_word_t w);
        map_fields_t f;
        f.io_mode = w[15];
        f.region  = w[13:12];
        f.segment = w[9:0];
        return f;
    endfunction

    function automatic map_word_t reset_map(input int idx, input int count);
        return (idx == count - 1) ? 16'h0000 : 16'h2000;
    endfunction

endpackage

// File: rtl/dwt_regs.sv
module dwt_regs
    import dwt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int SEL_W = $clog2(NUM_WIN)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  map_word_t                      wdata,
    output map_word_t                      rdata,
    output logic [NUM_WIN-1:0][MAP_W-1:0]  regs_o
);

    logic [NUM_WIN-1:0][MAP_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= reset_map(g, NUM_WIN);
            end else if (we && (sel == SEL_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    assign rdata  = regs_q[sel];
    assign regs_o = regs_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(sel)] == $past(wdata)); // R2

    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs_q[0] == 16'h2000 && regs_q[NUM_WIN-1] == 16'h0000)); // R1

endmodule

// File: rtl/dwt_split.sv
module dwt_split #(
    parameter int LOG_W    = 17,
    parameter int WIN_BITS = 14,
    parameter int NUM_WIN  = 4,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(NUM_WIN),
    localparam int CMP_W   = (CNT_W > WIN_BITS + 1) ? CNT_W : WIN_BITS + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LOG_W-1:0]    laddr,
    input  logic [CNT_W-1:0]    req,
    output logic [IDX_W-1:0]    idx,
    output logic [WIN_BITS-1:0] off,
    output logic                out_of_range,
    output logic [CNT_W-1:0]    clipped
);

    localparam logic [LOG_W:0] LIMIT = (LOG_W+1)'(NUM_WIN) << WIN_BITS;
    localparam logic [CMP_W-1:0] WIN_SIZE = CMP_W'(1) << WIN_BITS;

    logic [CMP_W-1:0] room;
    logic [CMP_W-1:0] req_ext;

    assign out_of_range = {1'b0, laddr} >= LIMIT;
    assign idx          = laddr[WIN_BITS +: IDX_W];
    assign off          = laddr[WIN_BITS-1:0];
    assign room         = WIN_SIZE - CMP_W'(off);
    assign req_ext      = CMP_W'(req);
    assign clipped      = (req_ext <= room) ? req : CNT_W'(room);

    AST_CLIP_NOT_ABOVE_REQ: assert property (@(posedge clk) disable iff (rst)
        clipped <= req); // R4

    AST_CLIP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (clipped != '0)); // R4

endmodule

// File: rtl/dwt_map.sv
module dwt_map
    import dwt_pkg::*;
#(
    parameter int WIN_BITS = 14,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  map_word_t           map,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WIN_BITS-1:0] off,
    output map_result_t         res
);

    map_fields_t f;
    logic [1:0]  sub;
    logic [3:0]  nib;
    logic [31:0] seg_win;
    logic [31:0] off32;

    assign f       = split_map(map);
    assign sub     = off[IO_BANK_SH +: 2];
    assign nib     = map[4*(3 - int'(sub)) +: 4];
    assign seg_win = 32'(f.segment) << WIN_BITS;
    assign off32   = 32'(off);

    always_comb begin
        res.addr  = '0;
        res.space = SP_NONE;
        res.bad   = 1'b0;
        if (f.io_mode) begin
            res.addr  = DATA_BASE + (32'(nib) << IO_STRIDE_SH) + IO_LOW + off32;
            res.space = SP_IO;
        end else begin
            unique case (f.region)
                2'b00: begin
                    res.addr  = UNI_BASE + seg_win + off32;
                    res.space = SP_UNIFIED;
                end
                2'b01: begin
                    res.addr  = INSN_BASE + seg_win + off32;
                    res.space = SP_INSN;
                end
                2'b10: begin
                    res.addr  = DATA_BASE + (32'(f.segment) << DSEG_SH)
                              + (32'(idx) << WIN_BITS) + off32;
                    res.space = SP_DATA;
                end
                default: begin
                    res.bad = 1'b1;
                end
            endcase
        end
    end

    AST_RESERVED_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (!map[15] && map[13:12] == 2'b11) |-> (res.bad && res.space == SP_NONE)); // R8

    AST_IO_HIGH_QUARTER: assert property (@(posedge clk) disable iff (rst)
        (res.space == SP_IO) |-> (res.addr[15:14] == 2'b11)); // R9

endmodule

// File: rtl/dwt_translator.sv
module dwt_translator
    import dwt_pkg::*;
#(
    parameter int LOG_W    = 17,
    parameter int WIN_BITS = 14,
    parameter int NUM_WIN  = 4,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  log_addr,
    input  logic [CNT_W-1:0]  req_len,
    input  logic              map_we,
    input  logic [IDX_W-1:0]  map_sel,
    input  logic [MAP_W-1:0]  map_wdata,
    output logic [MAP_W-1:0]  map_rd,
    output logic [31:0]       phys_addr,
    output logic [CNT_W-1:0]  grant_len,
    output logic [2:0]        space_tag,
    output logic              fault
);

    logic [NUM_WIN-1:0][MAP_W-1:0] regs;
    logic [IDX_W-1:0]              idx;
    logic [WIN_BITS-1:0]           off;
    logic                          oor;
    logic [CNT_W-1:0]              clipped;
    map_result_t                   mres;

    dwt_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk(clk), .rst(rst), .we(map_we), .sel(map_sel),
        .wdata(map_wdata), .rdata(map_rd), .regs_o(regs)
    );

    dwt_split #(.LOG_W(LOG_W), .WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_split (
        .clk(clk), .rst(rst), .laddr(log_addr), .req(req_len),
        .idx(idx), .off(off), .out_of_range(oor), .clipped(clipped)
    );

    dwt_map #(.WIN_BITS(WIN_BITS), .IDX_W(IDX_W)) u_map (
        .clk(clk), .rst(rst), .map(regs[idx]), .idx(idx), .off(off), .res(mres)
    );

    always_comb begin
        fault     = oor || mres.bad;
        phys_addr = fault ? '0 : mres.addr;
        grant_len = fault ? '0 : clipped;
        space_tag = fault ? SP_NONE : mres.space;
    end

    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, log_addr} >= ((LOG_W+1)'(NUM_WIN) << WIN_BITS))
            |-> (fault && space_tag == 3'd7 && grant_len == '0)); // R3

    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        fault |-> (phys_addr == '0 && grant_len == '0)); // R8

endmodule

// File: tb/dwt_translator_test.sv
`timescale 1ns/1ps
module dwt_translator_test;

    typedef struct {
        logic [31:0] phys;
        logic [15:0] grant;
        logic [2:0]  tag;
        logic        flt;
        logic [15:0] rd;
        string       name;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] log_addr = '0;
    logic [15:0] req_len = '0;
    logic        map_we = 1'b0;
    logic [1:0]  map_sel = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rd;
    logic [31:0] phys_addr;
    logic [15:0] grant_len;
    logic [2:0]  space_tag;
    logic        fault;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    item_t exp_q[$];
    logic [15:0] shadow [4];

    always #2 clk = ~clk;

    dwt_translator uut (
        .clk(clk), .rst(rst), .log_addr(log_addr), .req_len(req_len),
        .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
        .map_rd(map_rd), .phys_addr(phys_addr), .grant_len(grant_len),
        .space_tag(space_tag), .fault(fault)
    );

    function automatic item_t model(input logic [16:0] la, input logic [15:0] cnt,
                                    input logic [1:0] sel, input string name);
        item_t e;
        int unsigned off, wi, room, k, nib, seg;
        logic [15:0] m;
        e.name = name;
        e.rd = shadow[sel];
        e.phys = 0; e.grant = 0; e.tag = 3'd7; e.flt = 1'b1;
        if (la >= 17'h10000) return e;
        wi = la / 32'h4000;
        off = la % 32'h4000;
        m = shadow[wi];
        seg = m & 16'h03FF;
        room = 32'h4000 - off;
        e.grant = (cnt < room) ? cnt : 16'(room);
        e.flt = 1'b0;
        if (m[15]) begin
            k = off / 32'h1000;
            nib = (m >> (4 * (3 - k))) & 4'hF;
            e.phys = 32'h0200_0000 + nib * 32'h10000 + 32'hC000 + off;
            e.tag = 3'd3;
        end else begin
            case (m[13:12])
                2'b00: begin e.phys = seg * 32'h4000 + off; e.tag = 3'd0; end
                2'b01: begin e.phys = 32'h0100_0000 + seg * 32'h4000 + off; e.tag = 3'd1; end
                2'b10: begin e.phys = 32'h0200_0000 + (seg << 16) + wi * 32'h4000 + off; e.tag = 3'd2; end
                default: begin e.flt = 1'b1; e.grant = 0; e.tag = 3'd7; end
            endcase
        end
        return e;
    endfunction

    task automatic step(input logic [16:0] la, input logic [15:0] cnt, input logic we,
                        input logic [1:0] sel, input logic [15:0] wd, input string name);
        @(posedge clk);
        #1;
        log_addr = la; req_len = cnt; map_we = we; map_sel = sel; map_wdata = wd;
        exp_q.push_back(model(la, cnt, sel, name));
        if (we) shadow[sel] = wd;
    endtask

    task automatic look(input logic [16:0] la, input logic [15:0] cnt, input string name);
        step(la, cnt, 1'b0, 2'd0, 16'h0, name);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e;
            e = exp_q.pop_front();
            total++;
            if (phys_addr !== e.phys || grant_len !== e.grant || space_tag !== e.tag ||
                fault !== e.flt || map_rd !== e.rd) begin
                bad++;
                $display("FAIL %s: got phys=%h grant=%h tag=%0d fault=%b rd=%h exp phys=%h grant=%h tag=%0d fault=%b rd=%h",
                         e.name, phys_addr, grant_len, space_tag, fault, map_rd,
                         e.phys, e.grant, e.tag, e.flt, e.rd);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = (i == 3) ? 16'h0000 : 16'h2000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset values seen through read-back
        for (int i = 0; i < 4; i++) step(17'h0, 16'h1, 1'b0, 2'(i), 16'h0, "R1 reset readback");
        // R7 default data mapping, windows 0 and 1
        look(17'h00123, 16'h4, "R7 data win0");
        look(17'h04010, 16'h4, "R7 data win1 index term");
        // R5 window 3 resets to unified seg 0
        look(17'h0C004, 16'h2, "R5 unified win3");
        // R2: write reg3, same-cycle translation uses old value
        step(17'h0C004, 16'h2, 1'b1, 2'd3, 16'h1005, "R2 same-cycle old value");
        step(17'h0C004, 16'h2, 1'b0, 2'd3, 16'h0, "R2 R6 new value insn seg5");
        // R5 unified with nonzero segment
        step(17'h08020, 16'h8, 1'b1, 2'd2, 16'h0003, "R2 write reg2");
        look(17'h08020, 16'h8, "R5 unified seg3");
        // R7 data segment shift
        step(17'h04100, 16'h8, 1'b1, 2'd1, 16'h2007, "R2 write reg1");
        look(17'h04100, 16'h8, "R7 data seg7 win1");
        // R8 reserved region
        step(17'h00010, 16'h8, 1'b1, 2'd0, 16'h3000, "R2 write reg0 reserved");
        look(17'h00010, 16'h8, "R8 reserved faults");
        // R9 I/O mode, region bits set to 01 must be ignored
        step(17'h00010, 16'h8, 1'b1, 2'd0, 16'h9ABC, "R2 write reg0 io");
        look(17'h00010, 16'h8, "R9 io sub0 top nibble");
        look(17'h01FFF, 16'h8, "R9 io sub1");
        look(17'h02000, 16'h8, "R9 io sub2");
        look(17'h03FF0, 16'h40, "R9 R4 io sub3 clipped");
        // R4 clipping corners
        look(17'h04000, 16'h4000, "R4 full window grant");
        look(17'h04000, 16'h4001, "R4 over window clipped");
        look(17'h07FFF, 16'h0010, "R4 last byte");
        look(17'h04100, 16'h0000, "R4 zero request");
        // R3 range faults
        look(17'h10000, 16'h10, "R3 first out of range");
        look(17'h1FFFF, 16'h10, "R3 top out of range");
        look(17'h0FFFF, 16'h10, "R3 last in range");
        // R6 instruction segment on window 3 again after reset value replaced
        step(17'h0FFFF, 16'h10, 1'b1, 2'd3, 16'h13FF, "R2 write reg3 max seg");
        look(17'h0C000, 16'h10, "R6 insn seg 0x3FF");
        for (int i = 0; i < 4; i++) step(17'h0, 16'h1, 1'b0, 2'(i), 16'h0, "R2 final readback");
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule